// File: doc/BRIEF.md
# Wavefront Matrix Multiply Array

This block multiplies two square signed fixed-point matrices, C = A x B, on an N x N grid of identical multiply-accumulate cells. There is no central scheduler. Every cell holds a one-entry operand buffer on its left side and one on its top side. A cell acts as soon as both buffers are full and both of its downstream neighbours have room. When it acts, it passes the A operand one cell to the right and the B operand one cell down, and it adds their product into its own accumulator. Activity begins in the top-left cell and moves across the grid along anti-diagonals. Later recursions follow close behind the earlier ones, and local flow control keeps them from overtaking each other.

Operands come in through feeder ports on the grid edges. Each row of the grid has an A-side feeder and each column has a B-side feeder. Both use a valid/ready handshake. A start pulse clears the grid and opens the feeders. When every cell has performed N accumulations, the done level rises. All N x N results are then visible on a flat result bus, and they stay there until the next start pulse.

Top module: `wmm_array`

## Requirements
- R1: A start pulse clears every accumulator to zero and drops done. Both take effect in the cycle after the pulse, and they apply even when a run is still in progress.
- R2: A-side feeder i carries element a(i,k) in bits [i*W +: W] of aData during the k-th transfer on that port. B-side feeder j carries b(k,j) in bits [j*W +: W] of bData during the k-th transfer on its port. A transfer happens on a clock edge where both valid and ready are high.
- R3: After a run, cell (i,j) holds the signed sum over k of a(i,k)*b(k,j). It appears on cOut at bits [(i*N+j)*ACCW +: ACCW], where ACCW = 2W + ceil(log2 N).
- R4: Each feeder port accepts exactly N operands per run. After the N-th transfer its ready stays low, and any further values offered on it have no effect on the results.
- R5: done rises once every cell has completed N accumulations. It then stays high until the next start pulse.
- R6: While done is high and no start pulse is given, cOut does not change.
- R7: The results do not depend on feeder timing. Ports may stall independently and by arbitrary amounts without changing any result.
- R8: The accumulator holds N products of the most negative operand without overflow, giving N*2^(2W-2).
- R9: After reset, before any start pulse, done is low, all feeder readies are low and cOut is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that clears the grid and begins a run |
| aValid | input | N | Per-row valid for A-side feeders |
| aData | input | N*W | A operands, row i at [i*W +: W], signed |
| aReady | output | N | Per-row ready for A-side feeders |
| bValid | input | N | Per-column valid for B-side feeders |
| bData | input | N*W | B operands, column j at [j*W +: W], signed |
| bReady | output | N | Per-column ready for B-side feeders |
| done | output | 1 | Level: all cells have completed N accumulations |
| cOut | output | N*N*ACCW | Accumulators, cell (i,j) at [(i*N+j)*ACCW +: ACCW], signed |

## Verification
The hardest situation to reach is one where recursions overlap while their fronts are skewed unevenly. In that case a cell's left buffer is full but its top buffer stays empty for many cycles, or a downstream neighbour holds it back. A single in-order feed never produces this. The stimulus therefore drops each feeder's valid independently at random, with stall rates up to 80 percent, so every port drifts out of step with the others. The stimulus also keeps offering junk values once each port is exhausted, and it restarts a run while operands are still in flight.

// File: rtl/wmm_pkg.sv
package wmm_pkg;
  // Per-cell strobes from control to datapath
  typedef struct packed {
    logic clear;  // wipe accumulator
    logic ldA;    // capture A operand into left buffer
    logic ldB;    // capture B operand into top buffer
    logic fire;   // multiply-accumulate and forward
  } cellStrb_t;
endpackage

// File: rtl/wmm_ctrl.sv
module wmm_ctrl
  import wmm_pkg::*;
#(
  parameter int N = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [N-1:0]          aValid,
  output logic [N-1:0]          aReady,
  input  logic [N-1:0]          bValid,
  output logic [N-1:0]          bReady,
  output cellStrb_t [N*N-1:0]   strb,
  output logic                  done
);
  localparam int CW = $clog2(N + 1);

  logic [N*N-1:0] aFull;
  logic [N*N-1:0] bFull;
  logic [N*N-1:0] fire;
  logic           run;
  logic [CW-1:0]  recLeft;

  for (genvar i = 0; i < N; i++) begin : gRow
    for (genvar j = 0; j < N; j++) begin : gCol
      localparam int IDX = i * N + j;
      logic          aF, bF;
      logic [CW-1:0] fires;
      logic          loadA, loadB, rightFree, downFree;

      assign aFull[IDX] = aF;
      assign bFull[IDX] = bF;

      if (j == 0) begin : gAEdge
        assign aReady[i] = run & ~aF & (fires < CW'(N));
        assign loadA     = aValid[i] & aReady[i];
      end else begin : gAIn
        assign loadA = fire[IDX-1];
      end

      if (i == 0) begin : gBEdge
        assign bReady[j] = run & ~bF & (fires < CW'(N));
        assign loadB     = bValid[j] & bReady[j];
      end else begin : gBIn
        assign loadB = fire[IDX-N];
      end

      if (j == N - 1) begin : gRSink
        assign rightFree = 1'b1;
      end else begin : gRNext
        assign rightFree = ~aFull[IDX+1];
      end

      if (i == N - 1) begin : gDSink
        assign downFree = 1'b1;
      end else begin : gDNext
        assign downFree = ~bFull[IDX+N];
      end

      assign fire[IDX] = aF & bF & rightFree & downFree;
      assign strb[IDX] = {start, loadA, loadB, fire[IDX]};

      always_ff @(posedge clk) begin
        if (!rstN || start) begin
          aF    <= 1'b0;
          bF    <= 1'b0;
          fires <= '0;
        end else begin
          if (loadA)          aF <= 1'b1;
          else if (fire[IDX]) aF <= 1'b0;
          if (loadB)          bF <= 1'b1;
          else if (fire[IDX]) bF <= 1'b0;
          if (fire[IDX])      fires <= fires + 1'b1;
        end
      end
    end
  end

  // Recursion counter: the far corner finishes each recursion last
  always_ff @(posedge clk) begin
    if (!rstN) begin
      run     <= 1'b0;
      recLeft <= '0;
    end else if (start) begin
      run     <= 1'b1;
      recLeft <= CW'(N);
    end else if (fire[N*N-1] && recLeft != '0) begin
      recLeft <= recLeft - 1'b1;
    end
  end

  assign done = run & (recLeft == '0);
endmodule

// File: rtl/wmm_dp.sv
module wmm_dp
  import wmm_pkg::*;
#(
  parameter int N    = 3,
  parameter int W    = 8,
  parameter int ACCW = 2 * W + $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cellStrb_t [N*N-1:0]   strb,
  input  logic [N*W-1:0]        aData,
  input  logic [N*W-1:0]        bData,
  output logic [N*N*ACCW-1:0]   cOut
);
  logic [W-1:0] aBufAll [N*N];
  logic [W-1:0] bBufAll [N*N];

  for (genvar i = 0; i < N; i++) begin : gRow
    for (genvar j = 0; j < N; j++) begin : gCol
      localparam int IDX = i * N + j;
      logic signed [W-1:0]    aBuf, bBuf;
      logic signed [2*W-1:0]  prod;
      logic signed [ACCW-1:0] acc;
      logic [W-1:0]           aSrc, bSrc;

      if (j == 0) begin : gASrcEdge
        assign aSrc = aData[i*W +: W];
      end else begin : gASrcCell
        assign aSrc = aBufAll[IDX-1];
      end

      if (i == 0) begin : gBSrcEdge
        assign bSrc = bData[j*W +: W];
      end else begin : gBSrcCell
        assign bSrc = bBufAll[IDX-N];
      end

      assign prod = aBuf * bBuf;
      assign aBufAll[IDX] = aBuf;
      assign bBufAll[IDX] = bBuf;
      assign cOut[IDX*ACCW +: ACCW] = acc;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          aBuf <= '0;
          bBuf <= '0;
          acc  <= '0;
        end else begin
          if (strb[IDX].ldA) aBuf <= aSrc;
          if (strb[IDX].ldB) bBuf <= bSrc;
          if (strb[IDX].clear)     acc <= '0;
          else if (strb[IDX].fire) acc <= acc + ACCW'(prod);
        end
      end
    end
  end
endmodule

// File: rtl/wmm_array.sv
module wmm_array
  import wmm_pkg::*;
#(
  parameter int N = 3,
  parameter int W = 8,
  localparam int ACCW = 2 * W + $clog2(N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [N-1:0]        aValid,
  input  logic [N*W-1:0]      aData,
  output logic [N-1:0]        aReady,
  input  logic [N-1:0]        bValid,
  input  logic [N*W-1:0]      bData,
  output logic [N-1:0]        bReady,
  output logic                done,
  output logic [N*N*ACCW-1:0] cOut
);
  cellStrb_t [N*N-1:0] strb;

  wmm_ctrl #(.N(N)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .aValid(aValid), .aReady(aReady),
    .bValid(bValid), .bReady(bReady),
    .strb(strb), .done(done)
  );

  wmm_dp #(.N(N), .W(W), .ACCW(ACCW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .aData(aData), .bData(bData), .cOut(cOut)
  );
endmodule

// File: rtl/wmm_chk.sv
module wmm_chk #(
  parameter int N = 3,
  parameter int W = 8,
  localparam int ACCW = 2 * W + $clog2(N)
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [N-1:0]        aReady,
  input logic [N-1:0]        bReady,
  input logic                done,
  input logic [N*N*ACCW-1:0] cOut
);
  // R1
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (cOut == '0 && !done));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R4
  feed_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (aReady == '0 && bReady == '0));

  // R6
  result_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> $stable(cOut));
endmodule

bind wmm_array wmm_chk #(.N(N), .W(W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .aReady(aReady),
  .bReady(bReady), .done(done), .cOut(cOut)
);

// File: tb/wmm_array_tb_top.sv
`timescale 1ns/1ps
module wmm_array_tb_top;
  localparam int N = 3;
  localparam int W = 8;
  localparam int ACCW = 2 * W + $clog2(N);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic [N-1:0]        aValid = '0;
  logic [N*W-1:0]      aData = '0;
  logic [N-1:0]        aReady;
  logic [N-1:0]        bValid = '0;
  logic [N*W-1:0]      bData = '0;
  logic [N-1:0]        bReady;
  logic                done;
  logic [N*N*ACCW-1:0] cOut;

  int mA [N][N];
  int mB [N][N];
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wmm_array #(.N(N), .W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .aValid(aValid), .aData(aData), .aReady(aReady),
    .bValid(bValid), .bData(bData), .bReady(bReady),
    .done(done), .cOut(cOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint expC(int i, int j);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(mA[i][k]) * longint'(mB[k][j]);
    return s;
  endfunction

  function automatic longint cellOut(int i, int j);
    logic signed [ACCW-1:0] v;
    v = cOut[(i*N+j)*ACCW +: ACCW];
    return longint'(v);
  endfunction

  function automatic int rndVal();
    return int'($urandom_range(2**W - 1)) - 2**(W-1);
  endfunction

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R1: cleared and not done one edge after the pulse
    check(cOut == '0, "R1", "cOut cleared after start", longint'(cOut != '0), 0);
    check(done == 1'b0, "R1", "done low after start", longint'(done), 0);
  endtask

  task automatic feedRun(input int gapPct, input int maxCyc, input bit doCheck,
                         input string resReq);
    int aIdx [N];
    int bIdx [N];
    bit extraTaken = 1'b0;
    int cyc = 0;
    for (int p = 0; p < N; p++) begin aIdx[p] = 0; bIdx[p] = 0; end
    while (!done && cyc < maxCyc) begin
      @(negedge clk);
      cyc++;
      for (int p = 0; p < N; p++) begin
        if (aIdx[p] < N) begin
          aValid[p] = (int'($urandom_range(99)) >= gapPct);
          aData[p*W +: W] = W'(mA[p][aIdx[p]]);
        end else begin
          aValid[p] = 1'b1;  // R4: junk offered after the last operand
          aData[p*W +: W] = W'($urandom);
        end
        if (bIdx[p] < N) begin
          bValid[p] = (int'($urandom_range(99)) >= gapPct);
          bData[p*W +: W] = W'(mB[bIdx[p]][p]);
        end else begin
          bValid[p] = 1'b1;
          bData[p*W +: W] = W'($urandom);
        end
      end
      #1;
      for (int p = 0; p < N; p++) begin
        if (aValid[p] && aReady[p]) begin
          if (aIdx[p] < N) aIdx[p]++; else extraTaken = 1'b1;
        end
        if (bValid[p] && bReady[p]) begin
          if (bIdx[p] < N) bIdx[p]++; else extraTaken = 1'b1;
        end
      end
    end
    aValid = '0;
    bValid = '0;
    if (doCheck) begin
      check(extraTaken == 1'b0, "R4", "extra operand accepted", longint'(extraTaken), 0);
      check(done == 1'b1, "R5", "done after N recursions", longint'(done), 1);
      check(aReady == '0 && bReady == '0, "R4", "readies closed",
            longint'({aReady, bReady}), 0);
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          check(cellOut(i, j) == expC(i, j), resReq, $sformatf("c(%0d,%0d)", i, j),
                cellOut(i, j), expC(i, j));
      repeat (3) @(negedge clk);
      check(done == 1'b1, "R5", "done held", longint'(done), 1);
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          check(cellOut(i, j) == expC(i, j), "R6", $sformatf("c(%0d,%0d) held", i, j),
                cellOut(i, j), expC(i, j));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R5 watchdog: actual %0d expected %0d (done)", done, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1982));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(done == 1'b0, "R9", "done after reset", longint'(done), 0);
    check(aReady == '0 && bReady == '0, "R9", "readies after reset",
          longint'({aReady, bReady}), 0);
    check(cOut == '0, "R9", "cOut after reset", longint'(cOut != '0), 0);

    // R2 R3: directed, B is identity so C equals A
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mA[i][j] = i * N + j - 4;
        mB[i][j] = (i == j) ? 1 : 0;
      end
    pulseStart();
    feedRun(0, 2000, 1'b1, "R2");

    // R8: most negative operands everywhere
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mA[i][j] = -(2**(W-1));
        mB[i][j] = -(2**(W-1));
      end
    pulseStart();
    feedRun(20, 2000, 1'b1, "R8");
    check(cellOut(N-1, N-1) == longint'(N) * (64'sd1 << (2*W-2)), "R8",
          "corner extreme", cellOut(N-1, N-1), longint'(N) * (64'sd1 << (2*W-2)));

    // R8: most negative times most positive
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) mB[i][j] = 2**(W-1) - 1;
    pulseStart();
    feedRun(0, 2000, 1'b1, "R8");

    // R1: restart in the middle of a run, then a full run
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin mA[i][j] = rndVal(); mB[i][j] = rndVal(); end
    pulseStart();
    feedRun(0, 4, 1'b0, "R1");
    pulseStart();
    feedRun(10, 2000, 1'b1, "R1");

    // R3 R7: random values under increasingly uneven feeder stalls
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin mA[i][j] = rndVal(); mB[i][j] = rndVal(); end
      pulseStart();
      feedRun((r * 16) % 85, 4000, 1'b1, (r < 2) ? "R3" : "R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule